// File: doc/BRIEF.md
# SPI Storage-Card Host Port for an 8-bit I/O Bus

This block lets a small 8-bit processor talk to up to two SD cards in SPI mode through four adjacent I/O port addresses. Software loads an outgoing byte, then touches a separate trigger port. A write to the trigger sends the loaded byte. A read of the trigger clocks in one byte from the card while the line to the card is held high. The exchange runs in hardware while software polls a busy flag in the status port.

The serial clock has two rates. The slow rate is used while a card is identified and the fast rate for bulk transfer. Each card has its own chip select. Software writes the select port with active-low bits and reads them back as active-high flags. Command framing, CRC and card bring-up are handled by software.

Top module: `spi_sd_port`

## Requirements
- R1: After reset both chip selects are high, `sck` is low, `mosi` is high, the status port reads 0x00 and the speed port reads 0x00.
- R2: The block answers only at addresses BASE_ADDR+0 (data), +1 (speed), +2 (select on write, status on read) and +3 (trigger). An access to any other address changes no state and starts no transfer.
- R3: Writing the select port drives bit 0 to `cs_n[0]` and bit 1 to `cs_n[1]` without inversion. Status bit 0 reads 1 while `cs_n[0]` is low, and status bit 1 reads 1 while `cs_n[1]` is low.
- R4: Speed port bit 0 picks the serial clock rate. With 0, each `sck` half period lasts SLOW_HALF clock cycles. With 1, it lasts FAST_HALF cycles. The bit reads back at bit 0 of the speed port.
- R5: A write of any value to the trigger port sends the data register MSB first in SPI mode 0, with exactly 8 rising `sck` edges. `mosi` never changes at a rising `sck` edge.
- R6: A read of the trigger port starts a receive. `mosi` stays high for the whole byte and `miso` is sampled on each rising edge, MSB first. Once busy clears, the data port returns the received byte.
- R7: Status bit 7 reads 1 from the cycle after a trigger until the 8th falling `sck` edge, then 0. Whenever the block is idle, `sck` is low and `mosi` is high.
- R8: While busy, writes to the data, speed and select ports are ignored.
- R9: A trigger access while busy is ignored: the running transfer still produces exactly 8 rising edges, and no second transfer follows.
- R10: A transmit does not change the data register, so after a send the data port still returns the byte that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| sck | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |
| cs_n | output | NUM_CS | Active-low card chip selects |

## Verification
A wrong bit counter or clock-divider state would show up within one byte time. It would appear as a count other than eight `sck` rising edges, as a half period that does not match the chosen rate, or as busy staying set. A corrupted shift register would show up at the data port or in the bit stream the card model captures on the next transfer. Ignored writes during a transfer are checked by reading the registers back once the transfer has finished. A select register that takes a write while busy would show on `cs_n` one cycle later.

// File: rtl/spi_sd_pkg.sv
package spi_sd_pkg;
  localparam int BYTE_W   = 8;
  localparam int BUSY_BIT = 7;

  typedef enum logic [1:0] {
    OFS_DATA   = 2'd0,
    OFS_SPEED  = 2'd1,
    OFS_SELECT = 2'd2,
    OFS_ACTION = 2'd3
  } port_ofs_e;
endpackage

// File: rtl/spi_sd_clkgen.sv
module spi_sd_clkgen #(
  parameter int SLOW_HALF = 15625,
  parameter int FAST_HALF = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= limit)); // R4
endmodule

// File: rtl/spi_sd_shifter.sv
module spi_sd_shifter
  import spi_sd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rx_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sck       <= 1'b0;
      mosi      <= 1'b1;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      rx_mode_q <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy && (start_tx || start_rx)) begin
        busy      <= 1'b1;
        sck       <= 1'b0;
        bit_q     <= '0;
        rx_mode_q <= start_rx;
        sh_q      <= start_rx ? '1 : tx_byte;
        mosi      <= start_rx ? 1'b1 : tx_byte[BYTE_W-1];
      end else if (busy && tick) begin
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[BYTE_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q == BIT_W'(BYTE_W - 1)) begin
            busy     <= 1'b0;
            mosi     <= 1'b1;
            rx_valid <= rx_mode_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            mosi  <= sh_q[BYTE_W-2];
          end
        end
      end
    end
  end

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck); // R7
  AST_MOSI_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mosi); // R7
  AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi)); // R5
  AST_RX_MOSI_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_mode_q) |-> mosi); // R6
  AST_RXV_IDLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !busy); // R6
endmodule

// File: rtl/spi_sd_regs.sv
module spi_sd_regs
  import spi_sd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h6C,
  parameter int NUM_CS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              busy,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              fast_sel,
  output logic [NUM_CS-1:0] cs_n,
  output logic              start_tx,
  output logic              start_rx
);
  logic [ADDR_W-1:0] rel;
  logic              hit;
  port_ofs_e         ofs;
  logic              wr_ok;
  logic [BYTE_W-1:0] data_q;
  logic [NUM_CS-1:0] sel_q;
  logic              fast_q;
  logic [7:0]        status;

  assign rel   = bus_addr - ADDR_W'(BASE_ADDR);
  assign hit   = (rel[ADDR_W-1:2] == '0);
  assign ofs   = port_ofs_e'(rel[1:0]);
  assign wr_ok = bus_wr && hit && !busy;

  assign start_tx = wr_ok && (ofs == OFS_ACTION);
  assign start_rx = bus_rd && hit && !busy && (ofs == OFS_ACTION);

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy;
  end

  genvar g;
  logic [7:0] sel_flags;
  generate
    for (g = 0; g < 8; g++) begin : g_flag
      if (g < NUM_CS) begin : g_cs
        assign sel_flags[g] = ~sel_q[g];
      end else begin : g_pad
        assign sel_flags[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      sel_q     <= '1;
      fast_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ok) begin
        case (ofs)
          OFS_DATA:   data_q <= bus_wdata;
          OFS_SPEED:  fast_q <= bus_wdata[0];
          OFS_SELECT: sel_q  <= bus_wdata[NUM_CS-1:0];
          default:    ;
        endcase
      end else if (rx_valid) begin
        data_q <= rx_byte;
      end
      if (bus_rd && hit) begin
        case (ofs)
          OFS_SPEED:  bus_rdata <= {7'd0, fast_q};
          OFS_SELECT: bus_rdata <= status | sel_flags;
          default:    bus_rdata <= data_q;
        endcase
      end
    end
  end

  assign tx_byte  = data_q;
  assign fast_sel = fast_q;
  assign cs_n     = sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cs_n)); // R8
  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fast_sel)); // R8
  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    (start_tx || start_rx) |=> busy); // R7
endmodule

// File: rtl/spi_sd_port.sv
module spi_sd_port
  import spi_sd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h6C,
  parameter int SLOW_HALF = 15625,
  parameter int FAST_HALF = 6,
  parameter int NUM_CS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic              busy;
  logic              tick;
  logic              fast_sel;
  logic              start_tx;
  logic              start_rx;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] tx_byte;

  spi_sd_regs #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CS(NUM_CS)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .fast_sel(fast_sel), .cs_n(cs_n),
    .start_tx(start_tx), .start_rx(start_rx)
  );

  spi_sd_clkgen #(
    .SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)
  ) u_clkgen (
    .clk(clk), .rst(rst), .run(busy), .fast(fast_sel), .tick(tick)
  );

  spi_sd_shifter u_shift (
    .clk(clk), .rst(rst), .tick(tick), .start_tx(start_tx),
    .start_rx(start_rx), .tx_byte(tx_byte), .miso(miso), .busy(busy),
    .sck(sck), .mosi(mosi), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );
endmodule

// File: tb/spi_sd_port_tb.sv
module spi_sd_port_tb;
  localparam int BASE = 'h6C;
  localparam int SLOW = 7;
  localparam int FAST = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, mosi, miso;
  logic [1:0] cs_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int cyc = 0;
  int t_rise = 0;
  int hp = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int fall_base = 0;
  logic [7:0] card_byte = 8'hFF;
  logic [7:0] mosi_sh = '0;

  always #4 clk = ~clk;

  spi_sd_port #(
    .ADDR_W(8), .BASE_ADDR(BASE), .SLOW_HALF(SLOW), .FAST_HALF(FAST), .NUM_CS(2)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always @(negedge clk) cyc <= cyc + 1;
  always @(posedge sck) begin
    rise_cnt <= rise_cnt + 1;
    mosi_sh  <= {mosi_sh[6:0], mosi};
    t_rise   <= cyc;
  end
  always @(negedge sck) begin
    fall_cnt <= fall_cnt + 1;
    hp       <= cyc - t_rise;
  end
  assign miso = ((fall_cnt - fall_base) < 8) ? card_byte[7 - (fall_cnt - fall_base)] : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 8'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 8'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int n = 0;
    s = 8'h80;
    while (s[7] && n < 3000) begin
      bus_read(BASE + 2, s);
      n++;
    end
    check(!s[7], tag, s, 0);
  endtask

  int rb;
  task automatic arm(input logic [7:0] cb);
    card_byte = cb;
    fall_base = fall_cnt;
    rb        = rise_cnt;
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 2'b11, "R1", cs_n, 3);
    check(sck == 1'b0, "R1", sck, 0);
    check(mosi == 1'b1, "R1", mosi, 1);
    bus_read(BASE + 2, d); check(d == 8'h00, "R1", d, 0);
    bus_read(BASE + 1, d); check(d == 8'h00, "R1", d, 0);

    // R3 select mapping, active-low out, active-high status
    for (int v = 0; v < 4; v++) begin
      bus_write(BASE + 2, 8'hFC | 8'(v));
      check(cs_n == 2'(v), "R3", cs_n, v);
      bus_read(BASE + 2, d);
      check(d == 8'(~v & 3), "R3", d, ~v & 3);
    end
    bus_write(BASE + 2, 8'hFF);

    // R2 out-of-window accesses do nothing
    bus_write(BASE + 6, 8'h00);
    bus_write(BASE - 2, 8'h00);
    check(cs_n == 2'b11, "R2", cs_n, 3);
    bus_write(BASE + 7, 8'h00);
    bus_read(BASE + 2, d); check(d[7] == 1'b0, "R2", d, 0);
    check(rise_cnt == 0, "R2", rise_cnt, 0);

    // R4 speed select and half period
    bus_write(BASE + 1, 8'h01);
    bus_read(BASE + 1, d); check(d == 8'h01, "R4", d, 1);
    bus_write(BASE + 0, 8'h5A);
    arm(8'hFF);
    bus_write(BASE + 3, 8'h00);
    bus_read(BASE + 2, d); check(d[7] == 1'b1, "R7", d, 8'h80);
    wait_idle("R7");
    check(hp == FAST, "R4", hp, FAST);
    check(sck == 1'b0 && mosi == 1'b1, "R7", {sck, mosi}, 1);
    bus_write(BASE + 1, 8'h00);
    bus_read(BASE + 1, d); check(d == 8'h00, "R4", d, 0);
    arm(8'hFF);
    bus_write(BASE + 3, 8'h00);
    wait_idle("R7");
    check(hp == SLOW, "R4", hp, SLOW);

    // R5 / R10 sweep of every transmit byte at fast rate
    bus_write(BASE + 1, 8'h01);
    for (int v = 0; v < 256; v++) begin
      bus_write(BASE + 0, 8'(v));
      arm(8'(v ^ 8'hC3));
      bus_write(BASE + 3, 8'hAA);
      wait_idle("R7");
      check(mosi_sh == 8'(v), "R5", mosi_sh, v);
      check(rise_cnt - rb == 8, "R5", rise_cnt - rb, 8);
      bus_read(BASE + 0, d); check(d == 8'(v), "R10", d, v);
    end

    // R6 sweep of every receive byte
    for (int v = 0; v < 256; v++) begin
      arm(8'(v));
      bus_read(BASE + 3, d);
      wait_idle("R7");
      check(mosi_sh == 8'hFF, "R6", mosi_sh, 8'hFF);
      bus_read(BASE + 0, d); check(d == 8'(v), "R6", d, v);
    end

    // R8 / R9 writes and triggers during a slow transfer
    bus_write(BASE + 1, 8'h00);
    bus_write(BASE + 0, 8'hA5);
    arm(8'h00);
    bus_write(BASE + 3, 8'h00);
    bus_write(BASE + 0, 8'h3C);
    bus_write(BASE + 1, 8'h01);
    bus_write(BASE + 2, 8'h00);
    check(cs_n == 2'b11, "R8", cs_n, 3);
    bus_write(BASE + 3, 8'h00);
    bus_read(BASE + 3, d);
    wait_idle("R9");
    repeat (40) @(negedge clk);
    check(rise_cnt - rb == 8, "R9", rise_cnt - rb, 8);
    check(mosi_sh == 8'hA5, "R9", mosi_sh, 8'hA5);
    bus_read(BASE + 2, d); check(d == 8'h00, "R9", d, 0);
    bus_read(BASE + 0, d); check(d == 8'hA5, "R8", d, 8'hA5);
    bus_read(BASE + 1, d); check(d == 8'h00, "R8", d, 0);
    check(cs_n == 2'b11, "R8", cs_n, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule